// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken, using each branch's own recent outcome pattern. Low bits of the branch address select one entry in a table of shift registers. Each entry holds the most recent outcomes of the branches that map to it. The value in that entry then addresses a shared table of 2-bit saturating counters, and the upper bit of the chosen counter is the prediction. Because the counter is chosen by the recent pattern rather than by the address alone, a short loop whose trip count fits inside the pattern has its exit iteration predicted correctly.

The fetch side presents an address and reads the prediction in the same cycle. The resolve side presents a resolved branch (address and outcome) with a valid strobe. On that clock edge the counter addressed by the entry's current pattern moves one step towards the outcome, and the outcome is shifted into the entry.

Top module: `lhist_predictor`

## Requirements
- R1: After synchronous active-low reset, every history entry is zero and every counter holds weakly-taken (binary 10), so every address predicts taken.
- R2: The history entry is selected by address bits [7:2]. Addresses that differ only in bits [1:0] or above bit 7 share one entry.
- R3: `pred_taken` is combinational and equals bit 1 of the counter addressed by the selected entry's 6-bit pattern: taken for 11 and 10, not-taken for 01 and 00.
- R4: A taken update raises the addressed counter by one and clamps it at 11.
- R5: A not-taken update lowers the addressed counter by one and clamps it at 00.
- R6: An update adjusts the counter addressed by the pattern held before the update. It then shifts the outcome into bit 0 of the selected entry, with taken as 1, and the oldest bit (bit 5) is dropped. The result is visible to predictions from the next cycle.
- R7: An update changes only the selected history entry and the one addressed counter.
- R8: While `upd_valid` is low, no history entry and no counter changes, whatever the other update inputs are.
- R9: A single branch repeating the pattern taken, taken, taken, not-taken shows zero mispredictions once warm-up is over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction for `pred_pc` (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The bench targets both clamps: a design that wraps a counter would turn a long run of not-taken outcomes into a taken prediction, and a long taken run into a not-taken one. It sends updates with the strobe low and then sweeps all 64 entries, which catches any write that leaks through. It also exercises address aliasing on bits outside [7:2]; an off-by-one in the index slice would split shared entries or merge separate ones. Finally, a long pseudo-random sweep and a repeating four-trip loop pin down the order of the counter write and the shift. A design that addressed the counter with the post-shift pattern would train the wrong counter and keep mispredicting the loop exit.

// File: rtl/lhist_pkg.sv
// Package: shared counter type and the saturating step rule.
// Assumes 2-bit counters, where bit 1 is the predicted direction.
package lhist_pkg;
    typedef logic [1:0] sat2_t;

    localparam sat2_t SAT_STRONG_NT = 2'b00;
    localparam sat2_t SAT_WEAK_T    = 2'b10;
    localparam sat2_t SAT_STRONG_T  = 2'b11;

    // Move one step towards the outcome, clamping at both ends.
    function automatic sat2_t sat_step(input sat2_t cur, input logic taken);
        sat2_t nxt;
        if (taken)
            nxt = (cur == SAT_STRONG_T) ? cur : cur + 2'd1;
        else
            nxt = (cur == SAT_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction
endpackage

// File: rtl/lhist_hist_table.sv
// Table of per-branch outcome shift registers.
// Has two combinational read ports: port a for prediction and port b for update.
// On a write, the outcome enters bit 0 of the entry on port b.
// Assumes a synchronous active-low reset that clears every entry.
module lhist_hist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [HIST_W-1:0] rd_hist_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [HIST_W-1:0] rd_hist_b,
    input  logic              wr_en,
    input  logic              wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][HIST_W-1:0] hist_q;

    // Read both ports directly from the storage.
    assign rd_hist_a = hist_q[rd_idx_a];
    assign rd_hist_b = hist_q[rd_idx_b];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Per-entry register: clear on reset, shift in the outcome when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hist_q[e] <= '0;
            else if (wr_en && (rd_idx_b == IDX_W'(e)))
                hist_q[e] <= {hist_q[e][HIST_W-2:0], wr_taken};
        end
    end

    // R6: the newest outcome lands in bit 0 of the written entry.
    p_lsb_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(rd_idx_b)][0] == $past(wr_taken));

    // R6: older outcomes move up by one position.
    p_shift_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(rd_idx_b)][HIST_W-1:1] == $past(rd_hist_b[HIST_W-2:0]));

    // R8: no write strobe, no change anywhere in the table.
    p_idle_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist_q));
endmodule

// File: rtl/lhist_ctr_table.sv
// Table of 2-bit saturating direction counters, addressed by a history pattern.
// Has one combinational read port and one write port that steps a counter.
// Assumes a synchronous active-low reset that sets every counter to weakly taken.
module lhist_ctr_table
    import lhist_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output sat2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][1:0] cnt_q;

    // Current value of the counter being predicted from.
    assign rd_ctr = cnt_q[rd_idx];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
        // Per-entry counter: preset on reset, step when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[e] <= SAT_WEAK_T;
            else if (wr_en && (wr_idx == IDX_W'(e)))
                cnt_q[e] <= sat_step(cnt_q[e], wr_taken);
        end
    end

    // R4: a taken update never lowers the counter.
    p_taken_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> cnt_q[$past(wr_idx)] >= $past(cnt_q[wr_idx]));

    // R4: the top value is held under further taken updates.
    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cnt_q[wr_idx] == 2'b11) |=> cnt_q[$past(wr_idx)] == 2'b11);

    // R5: a not-taken update never raises the counter.
    p_ntaken_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> cnt_q[$past(wr_idx)] <= $past(cnt_q[wr_idx]));

    // R5: the bottom value is held under further not-taken updates.
    p_sat_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cnt_q[wr_idx] == 2'b00) |=> cnt_q[$past(wr_idx)] == 2'b00);

    // R8: the counters are frozen without a write strobe.
    p_idle_ctr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_q));
endmodule

// File: rtl/lhist_predictor.sv
// Top level: local-history two-level direction predictor.
// Address bits [IDX_LO+IDX_W-1:IDX_LO] pick a history entry. Its pattern
// addresses the counter table, for prediction and for update alike.
// Assumes at most one resolved branch per cycle. Prediction is combinational.
module lhist_predictor
    import lhist_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_LO = 2,
    parameter int IDX_W  = 6,
    parameter int HIST_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0]  pred_sel;
    logic [IDX_W-1:0]  upd_sel;
    logic [HIST_W-1:0] pred_hist;
    logic [HIST_W-1:0] upd_hist;
    sat2_t             pred_ctr;

    // Select history entries from the fetch address and the resolve address.
    assign pred_sel = pred_pc[IDX_HI:IDX_LO];
    assign upd_sel  = upd_pc[IDX_HI:IDX_LO];

    lhist_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (pred_sel),
        .rd_hist_a (pred_hist),
        .rd_idx_b  (upd_sel),
        .rd_hist_b (upd_hist),
        .wr_en     (upd_valid),
        .wr_taken  (upd_taken)
    );

    // The counter write uses the pattern held before this edge's shift.
    lhist_ctr_table #(.IDX_W(HIST_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_hist),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_hist),
        .wr_taken (upd_taken)
    );

    // The direction bit of the selected counter is the prediction.
    assign pred_taken = pred_ctr[1];

    // R1: straight out of reset, every address predicts taken.
    p_reset_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pred_taken);
endmodule

// File: tb/lhist_predictor_test.sv
`timescale 1ns/1ps
module lhist_predictor_test;
    localparam int HW = 6;
    localparam int NE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [HW-1:0] m_hist [NE];
    logic [1:0]    m_ctr  [1 << HW];

    always #2 clk = ~clk;

    lhist_predictor uut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic logic m_pred(input logic [31:0] pc);
        return m_ctr[m_hist[pc[7:2]]][1];
    endfunction

    task automatic m_update(input logic [31:0] pc, input logic t);
        logic [HW-1:0] h;
        h = m_hist[pc[7:2]];
        if (t) m_ctr[h] = (m_ctr[h] == 2'b11) ? 2'b11 : m_ctr[h] + 2'd1;
        else   m_ctr[h] = (m_ctr[h] == 2'b00) ? 2'b00 : m_ctr[h] - 2'd1;
        m_hist[pc[7:2]] = {h[HW-2:0], t};
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pred_taken=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: predict ppc (checked against the model), optionally update upc.
    task automatic step(input logic [31:0] ppc, input logic v, input logic [31:0] upc,
                        input logic t, input string req);
        @(negedge clk);
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
        #1;
        check(pred_taken, m_pred(ppc), req);
        @(posedge clk);
        if (v) m_update(upc, t);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < NE; i++) step(32'(i) << 2, 1'b0, '0, 1'b0, req);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int miss;
        for (int i = 0; i < NE; i++) m_hist[i] = '0;
        for (int i = 0; i < (1 << HW); i++) m_ctr[i] = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every entry predicts taken after reset.
        for (int i = 0; i < NE; i++) begin
            @(negedge clk); pred_pc = 32'(i) << 2; #1;
            check(pred_taken, 1'b1, "R1");
        end

        // R5: not-taken run on entry 0 keeps history 0 and clamps counter 0 at 00.
        for (int k = 0; k < 8; k++) step(32'h0, 1'b1, 32'h0, 1'b0, "R5");
        step(32'h0, 1'b0, '0, 1'b0, "R5");
        check(pred_taken, 1'b0, "R5_clamped_not_taken");

        // R4: taken run on entry 5 saturates counter 63, then stays taken.
        for (int k = 0; k < 14; k++) step(32'h14, 1'b1, 32'h14, 1'b1, "R4");
        step(32'h14, 1'b0, '0, 1'b0, "R4");
        check(pred_taken, 1'b1, "R4_clamped_taken");

        // R2: aliases on bits outside [7:2] hit the same entry.
        for (int k = 0; k < 6; k++) step(32'hABCD_0F03 + 32'(k << 8), 1'b1, 32'h0000_FF0C, 1'(k & 1), "R2");
        step(32'h0000_000F, 1'b0, '0, 1'b0, "R2");

        // R8: strobe low with varied address and outcome changes nothing.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            upd_valid = 1'b0; upd_pc = 32'(k * 36); upd_taken = 1'(k & 1);
            pred_pc = 32'(k * 36); #1;
            check(pred_taken, m_pred(32'(k * 36)), "R8");
        end
        sweep("R8");

        // R9: loop branch T T T N; no mispredictions after warm-up.
        miss = 0;
        for (int it = 0; it < 40; it++) begin
            for (int p = 0; p < 4; p++) begin
                logic o;
                o = (p != 3);
                @(negedge clk);
                pred_pc = 32'h40; upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = o; #1;
                if (it >= 20 && pred_taken !== o) miss++;
                check(pred_taken, m_pred(32'h40), "R9_model");
                @(posedge clk);
                m_update(32'h40, o);
            end
        end
        checks++;
        if (miss != 0) begin
            fails++;
            $display("FAIL R9: mispredictions=%0d expected 0", miss);
        end

        // R3/R6/R7: pseudo-random updates over several entries, probing a different address.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] up, pp;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            up = {24'(lfsr), 8'h00} | (32'(lfsr[2:0]) << 2);
            pp = 32'(lfsr[7:5]) << 2;
            step(pp, 1'b1, up, lfsr[8] | lfsr[9], "R6");
            step(up, 1'b0, '0, 1'b0, "R3");
        end
        sweep("R7");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule